// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a simple 32-bit load/store core and chooses its next value on each enabled clock. It supports sequential flow, a direct jump to a decoded target, a jump through a register value, a call that saves a return address, and two-register conditional branches. The core has no condition flags. A branch is decided by comparing the two register operands directly.

The decode stage presents a 3-bit flow operation together with the jump target, the branch target and the two register operands. The block presents the next PC as a combinational value and registers it on the clock edge when `en` is high. A call writes its return address to a fixed link register. The block drives a write strobe, the register index and the data for that write. There is no return stack. A return is an ordinary register jump through the link register.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to zero at the next clock edge, whatever the values of `en` and `op`.
- R2: While `en` is low, `pc` keeps its value and `link_we` stays low.
- R3: Operation code 0 (sequential) loads `pc + 4`. The addition wraps modulo 2^32, so 0xFFFFFFFC is followed by 0.
- R4: Operation code 1 (direct jump) loads `jump_tgt`.
- R5: Operation code 2 (register jump) loads `rs_val`.
- R6: Operation code 3 (call) loads `jump_tgt`. In the same cycle it raises `link_we`, drives `link_data` with `pc + 4` and drives `link_idx` with 31.
- R7: Operation code 4 (branch if equal) loads `br_tgt` when `rs_val == rt_val`. Otherwise it loads `pc + 4`.
- R8: Operation code 5 (branch if not equal) loads `br_tgt` when `rs_val != rt_val`. Otherwise it loads `pc + 4`.
- R9: Every target address has its two low bits forced to zero before it is used. This applies to the jump target, the register value and the branch target, so `pc[1:0]` is always 0.
- R10: `link_we` is high only in a cycle with `en` high and operation code 3. Unused codes 6 and 7 behave like code 0.
- R11: `next_pc` always equals the value that `pc` takes at the next edge when `en` is high and `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable for the PC register |
| op | input | 3 | Flow operation code (0 seq, 1 jump, 2 register jump, 3 call, 4 branch equal, 5 branch not equal) |
| jump_tgt | input | 32 | Decoded jump/call target |
| br_tgt | input | 32 | Decoded branch target |
| rs_val | input | 32 | First register operand, also the register-jump target |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Value loaded on the next enabled edge |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address written on a call |

## Verification
The bench uses the default parameters: a 32-bit PC, two forced-zero low bits and 8-bit comparator slices, which gives four slices in the equality comparator. Some operand pairs differ in exactly one slice. This lets each slice alone make a branch decision go wrong. Jumps to 0xFFFFFFFC drive the sequential adder across its wrap point. A cycle-level reference model, written as plain integer arithmetic, is compared against `pc`, `next_pc` and the link outputs on every clock. It is run over directed cases and then over randomized operations that include the unused codes and enable gaps.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        FL_SEQ  = 3'd0,
        FL_JMP  = 3'd1,
        FL_JREG = 3'd2,
        FL_CALL = 3'd3,
        FL_BEQ  = 3'd4,
        FL_BNE  = 3'd5
    } flow_op_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/npc_align.sv
module npc_align #(
    parameter int W   = 32,
    parameter int LOW = 2
) (
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] addr_o
);
    generate
        if (LOW == 0) begin : g_pass
            assign addr_o = addr_i;
        end else begin : g_clear
            assign addr_o = {addr_i[W-1:LOW], {LOW{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/npc_eq.sv
module npc_eq #(
    parameter int W     = 32,
    parameter int SLICE = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o
);
    localparam int NSL = (W + SLICE - 1) / SLICE;

    logic [NSL-1:0] hit;

    generate
        for (genvar g = 0; g < NSL; g++) begin : g_slice
            localparam int LO = g * SLICE;
            localparam int HI = ((g + 1) * SLICE > W) ? W - 1 : (g + 1) * SLICE - 1;
            assign hit[g] = (a_i[HI:LO] == b_i[HI:LO]);
        end
    endgenerate

    assign eq_o = &hit;
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    pc,
    input  logic [W-1:0]    jmp_a,
    input  logic [W-1:0]    br_a,
    input  logic [W-1:0]    reg_a,
    input  logic            same,
    output logic [W-1:0]    nxt,
    output logic [W-1:0]    seq_pc,
    output logic            is_call
);
    logic take_br;

    always_comb begin
        seq_pc  = pc + W'(4);
        take_br = 1'b0;
        is_call = 1'b0;
        nxt     = seq_pc;
        case (op)
            FL_JMP:  nxt = jmp_a;
            FL_JREG: nxt = reg_a;
            FL_CALL: begin
                nxt     = jmp_a;
                is_call = 1'b1;
            end
            FL_BEQ:  take_br = same;
            FL_BNE:  take_br = !same;
            default: nxt = seq_pc;
        endcase
        if (take_br) nxt = br_a;
    end

    a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_BEQ && same) |-> nxt == br_a);
    a_r7_beq_fall: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_BEQ && !same) |-> nxt == pc + W'(4));
    a_r8_bne_taken: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_BNE && !same) |-> nxt == br_a);
    a_r8_bne_fall: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_BNE && same) |-> nxt == pc + W'(4));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          ALIGN_LOW = 2,
    parameter int          CMP_SLICE = 8,
    parameter int          REG_IDX_W = 5,
    parameter int          LINK_REG  = 31,
    parameter logic [31:0] RESET_PC  = 32'h0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [2:0]           op,
    input  logic [XLEN-1:0]      jump_tgt,
    input  logic [XLEN-1:0]      br_tgt,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    output logic [XLEN-1:0]      pc,
    output logic [XLEN-1:0]      next_pc,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    logic [XLEN-1:0] jmp_a, br_a, reg_a, nxt_d, seq_d;
    logic            same_d, call_d;

    npc_align #(.W(XLEN), .LOW(ALIGN_LOW)) u_al_jmp (.addr_i(jump_tgt), .addr_o(jmp_a));
    npc_align #(.W(XLEN), .LOW(ALIGN_LOW)) u_al_br  (.addr_i(br_tgt),   .addr_o(br_a));
    npc_align #(.W(XLEN), .LOW(ALIGN_LOW)) u_al_reg (.addr_i(rs_val),   .addr_o(reg_a));

    npc_eq #(.W(XLEN), .SLICE(CMP_SLICE)) u_eq (
        .a_i (rs_val),
        .b_i (rt_val),
        .eq_o(same_d)
    );

    npc_select #(.W(XLEN)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .op     (op),
        .pc     (st_q.pc),
        .jmp_a  (jmp_a),
        .br_a   (br_a),
        .reg_a  (reg_a),
        .same   (same_d),
        .nxt    (nxt_d),
        .seq_pc (seq_d),
        .is_call(call_d)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = XLEN'(RESET_PC);
        end else if (en) begin
            st_d.pc = nxt_d;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc        = st_q.pc;
    assign next_pc   = nxt_d;
    assign link_we   = en && call_d;
    assign link_idx  = REG_IDX_W'(LINK_REG);
    assign link_data = seq_d;

    a_r1_reset: assert property (@(posedge clk) rst |=> pc == XLEN'(RESET_PC));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc));
    a_r3_seq: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_SEQ) |=> pc == $past(pc) + XLEN'(4));
    a_r6_call: assert property (@(posedge clk) disable iff (rst)
        (en && op == FL_CALL) |=> pc == $past(jmp_a));
    a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[ALIGN_LOW-1:0] == '0);
    a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (en && op == FL_CALL));
    a_r11_commit: assert property (@(posedge clk) disable iff (rst)
        en |=> pc == $past(next_pc));
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [2:0]  op;
    logic [31:0] jump_tgt, br_tgt, rs_val, rt_val;
    logic [31:0] pc, next_pc, link_data;
    logic        link_we;
    logic [4:0]  link_idx;

    int n_chk = 0;
    int n_bad = 0;
    longint exp_pc;

    always #4 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .en(en), .op(op),
        .jump_tgt(jump_tgt), .br_tgt(br_tgt), .rs_val(rs_val), .rt_val(rt_val),
        .pc(pc), .next_pc(next_pc), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic longint al(input longint a);
        return (a / 4) * 4;
    endfunction

    function automatic longint model_next(input int o, input longint p, input longint j,
                                          input longint b, input longint s, input longint t);
        longint seqv = (p + 4) % 64'h1_0000_0000;
        if (o == 1 || o == 3) return al(j);
        if (o == 2) return al(s);
        if (o == 4) return (s == t) ? al(b) : seqv;
        if (o == 5) return (s != t) ? al(b) : seqv;
        return seqv;
    endfunction

    function automatic string req_of(input int o);
        case (o)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6, 7: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic step(input bit e, input int o, input logic [31:0] j, input logic [31:0] b,
                        input logic [31:0] s, input logic [31:0] t);
        longint nx;
        @(negedge clk);
        en = e; op = 3'(o); jump_tgt = j; br_tgt = b; rs_val = s; rt_val = t;
        #1;
        nx = model_next(o, exp_pc, j, b, s, t);
        chk(next_pc == 32'(nx), {req_of(o), "_R11 next_pc"}, next_pc, nx);
        chk(link_we == (e && o == 3), "R10 link_we", link_we, e && o == 3);
        if (e && o == 3) begin
            chk(link_data == 32'(exp_pc + 4), "R6 link_data", link_data, (exp_pc + 4) % 64'h1_0000_0000);
            chk(link_idx == 5'd31, "R6 link_idx", link_idx, 31);
        end
        @(posedge clk);
        #1;
        if (e) exp_pc = nx;
        chk(pc == 32'(exp_pc), e ? {req_of(o), " pc"} : "R2 pc hold", pc, exp_pc);
        chk(pc[1:0] == 2'b00, "R9 pc aligned", pc[1:0], 0);
    endtask

    task automatic do_reset(input bit e, input int o);
        @(negedge clk);
        rst = 1'b1; en = e; op = 3'(o);
        @(posedge clk);
        #1;
        rst = 1'b0;
        exp_pc = 0;
        chk(pc == 32'h0, "R1 reset pc", pc, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b0; en = 1'b0; op = 3'd0;
        jump_tgt = '0; br_tgt = '0; rs_val = '0; rt_val = '0;
        exp_pc = 0;
        do_reset(1'b0, 0);
        do_reset(1'b1, 3);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 3, 32'h100, 0, 0, 0);
        step(1, 1, 32'h0000_1003, 0, 0, 0);
        step(1, 2, 0, 0, 32'h0000_2222, 0);
        step(1, 3, 32'h0000_4001, 0, 0, 0);
        step(1, 4, 0, 32'h0000_0803, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
        for (int k = 0; k < 4; k++) begin
            step(1, 4, 0, 32'h0000_0900, 32'h1234_5678, 32'h1234_5678 ^ (32'h1 << (8 * k + 3)));
            step(1, 5, 0, 32'h0000_0A02, 32'h1234_5678, 32'h1234_5678 ^ (32'h1 << (8 * k + 5)));
        end
        step(1, 5, 0, 32'h0000_0B00, 32'h0F0F_0F0F, 32'h0F0F_0F0F);
        step(1, 1, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 6, 0, 0, 0, 0);
        step(1, 7, 32'h8000, 32'h8000, 1, 1);
        do_reset(1'b1, 1);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] bb = ($urandom % 3 == 0) ? a : 32'($urandom);
            step(($urandom % 5) != 0, int'($urandom % 8), $urandom, $urandom, a, bb);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule